// File: doc/BRIEF.md
# Reachability Closure Engine (Iterative Squaring)

The block holds a directed relation over N nodes as an N-by-N matrix of flip-flops. It turns that matrix into its transitive closure in place. A relation enters through a load port. On every clock cycle that the step enable is high, the block replaces the matrix with its Boolean self-product ORed with itself. After ceil(lg N) such steps, every path of any length has been folded in. The block then raises a completion flag and freezes the result.

Two read ports work on the frozen matrix. The first takes a source index and a target index and returns one bit: whether the target can be reached from the source. The second takes a source index and returns the whole row of nodes reachable from it. A mode input, sampled with the load, also marks every node as reachable from itself (reflexive closure). Results read before the completion flag is high carry no meaning.

The load port uses a valid/ready handshake. `ld_ready` is high after reset and whenever no closure is in progress. It goes low from the cycle after a load is accepted until the completion flag rises. While `ld_ready` is low, an offered relation is held off and has no effect. Once the flag is high, a new load is accepted again and restarts the process.

Top module: `reach_closure`

## Requirements
- R1: After reset, `closed` is 0 and `ld_ready` is 1.
- R2: A relation is taken when `ld_valid` and `ld_ready` are both high at a rising clock edge. Bit `r*N+c` of `ld_rel` set means an edge from node r to node c. From the next cycle until `closed` rises, `ld_ready` is 0.
- R3: If `refl_mode` is 1 when the load is taken, every node reaches itself in the result. If it is 0, a node reaches itself only through a cycle of length one or more.
- R4: While a closure is in progress, each rising edge with `step_en` high performs exactly one squaring step. Edges with `step_en` low change nothing.
- R5: `closed` stays 0 after the load and after the first ceil(lg N)-1 steps. It becomes 1 right after step number ceil(lg N). With N=1, it becomes 1 on the load itself.
- R6: Once `closed` is 1, it stays 1 and the result does not change, whatever `step_en` does, until the next load is taken.
- R7: When `closed` is 1, `q_hit` equals 1 exactly when node `q_col` can be reached from node `q_row` by a path of one or more edges (or when `q_row` equals `q_col` under R3's reflexive mode).
- R8: When `closed` is 1, bit c of `reach_row` is 1 exactly when node c can be reached from node `q_src`, by the same rule as R7.
- R9: A relation offered while `ld_ready` is 0 is not taken. The closure in progress finishes on its own relation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A relation is offered on `ld_rel` |
| ld_ready | output | 1 | The block can take a relation |
| ld_rel | input | N*N | Relation; bit r*N+c is the edge r to c |
| refl_mode | input | 1 | Sampled with the load; 1 selects reflexive closure |
| step_en | input | 1 | Permit one squaring step this cycle |
| closed | output | 1 | Closure complete; results are meaningful |
| q_row | input | IW | Source index for the single-bit query |
| q_col | input | IW | Target index for the single-bit query |
| q_hit | output | 1 | Reachability of `q_col` from `q_row` |
| q_src | input | IW | Source index for the row query |
| reach_row | output | N | Set of nodes reachable from `q_src` |

## Verification
The closure is exercised with five kinds of relation, each compared over all node pairs and all rows with a reference computed by a different method (Floyd–Warshall style relaxation):
- An empty relation shows whether the diagonal depends correctly on the mode.
- A forward chain through all eight nodes has the longest possible shortest path. It tells a full ceil(lg N)-step run apart from one that stops early, and it catches row/column transposition.
- A ring makes every entry 1, which shows that cycles produce self-reachability.
- Sparse pseudo-random graphs mix short paths and unreachable pairs.
- Stalled step sequences and a relation offered while the block is busy separate correct step counting and back-pressure from designs that count idle cycles or accept loads in the middle of a run.

// File: rtl/reach_pkg.sv
`timescale 1ns/1ps
package reach_pkg;
  // number of squaring steps needed for an n-node relation
  function automatic int sq_steps(input int n);
    return (n <= 1) ? 0 : $clog2(n);
  endfunction

  // width of a counter that must hold values 0..s
  function automatic int cnt_bits(input int s);
    return (s < 1) ? 1 : $clog2(s + 1);
  endfunction

  // width of a node index
  function automatic int idx_bits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/reach_ctrl.sv
`timescale 1ns/1ps
module reach_ctrl #(
  parameter int STEPS = 3,
  parameter int CW    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ld_fire,
  input  logic step_en,
  output logic running,
  output logic sq_fire,
  output logic done
);
  logic          loaded_q;
  logic [CW-1:0] cnt_q;
  logic          last_step;

  assign running   = loaded_q & ~done;
  assign sq_fire   = running & step_en;
  assign last_step = (cnt_q == CW'(STEPS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
      done     <= 1'b0;
      cnt_q    <= '0;
    end else if (ld_fire) begin
      loaded_q <= 1'b1;
      cnt_q    <= '0;
      done     <= (STEPS == 0);
    end else if (sq_fire) begin
      cnt_q <= cnt_q + CW'(1);
      if (last_step) done <= 1'b1;
    end
  end
endmodule

// File: rtl/reach_row_step.sv
`timescale 1ns/1ps
module reach_row_step #(
  parameter int N = 8
) (
  input  logic [N-1:0]   row_cur,
  input  logic [N*N-1:0] mat_flat,
  output logic [N-1:0]   row_nxt
);
  // next row = current row OR union of rows k for every k in current row
  always_comb begin
    row_nxt = row_cur;
    for (int k = 0; k < N; k++) begin
      if (row_cur[k]) row_nxt = row_nxt | mat_flat[k*N +: N];
    end
  end
endmodule

// File: rtl/reach_closure.sv
`timescale 1ns/1ps
module reach_closure #(
  parameter int N  = 8,
  parameter int IW = reach_pkg::idx_bits(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ld_valid,
  output logic           ld_ready,
  input  logic [N*N-1:0] ld_rel,
  input  logic           refl_mode,
  input  logic           step_en,
  output logic           closed,
  input  logic [IW-1:0]  q_row,
  input  logic [IW-1:0]  q_col,
  output logic           q_hit,
  input  logic [IW-1:0]  q_src,
  output logic [N-1:0]   reach_row
);
  localparam int STEPS = reach_pkg::sq_steps(N);
  localparam int CW    = reach_pkg::cnt_bits(STEPS);

  logic [N*N-1:0] mat_q;
  logic [N*N-1:0] sq_next;
  logic [N*N-1:0] diag_mask;
  logic [N*N-1:0] ld_value;
  logic           running;
  logic           sq_fire;
  logic           ld_fire;
  logic [N-1:0]   sel_row;

  assign ld_ready = ~running;
  assign ld_fire  = ld_valid & ld_ready;

  reach_ctrl #(.STEPS(STEPS), .CW(CW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_fire (ld_fire),
    .step_en (step_en),
    .running (running),
    .sq_fire (sq_fire),
    .done    (closed)
  );

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      assign diag_mask[r*N+c] = (r == c);
    end
    reach_row_step #(.N(N)) u_step (
      .row_cur  (mat_q[r*N +: N]),
      .mat_flat (mat_q),
      .row_nxt  (sq_next[r*N +: N])
    );
  end

  assign ld_value = refl_mode ? (ld_rel | diag_mask) : ld_rel;

  always_ff @(posedge clk) begin
    if (!rst_n)       mat_q <= '0;
    else if (ld_fire) mat_q <= ld_value;
    else if (sq_fire) mat_q <= sq_next;
  end

  assign sel_row   = mat_q[int'(q_row)*N +: N];
  assign q_hit     = sel_row[q_col];
  assign reach_row = mat_q[int'(q_src)*N +: N];
endmodule

// File: rtl/reach_closure_chk.sv
`timescale 1ns/1ps
module reach_closure_chk #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ld_valid,
  input logic           ld_ready,
  input logic [N*N-1:0] ld_rel,
  input logic           refl_mode,
  input logic           step_en,
  input logic           closed,
  input logic [IW-1:0]  q_row,
  input logic [IW-1:0]  q_col,
  input logic           q_hit,
  input logic [IW-1:0]  q_src,
  input logic [N-1:0]   reach_row
);
  localparam int STEPS = reach_pkg::sq_steps(N);

  logic seen_q, refl_q, take;
  assign take = ld_valid && ld_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      refl_q <= 1'b0;
    end else if (take) begin
      seen_q <= 1'b1;
      refl_q <= refl_mode;
    end
  end

  a_r2_busy_blocks_load: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !closed) |-> !ld_ready);

  a_r5_load_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (STEPS == 0 || !closed));

  a_r4_done_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(closed) |-> $past(step_en || ld_valid));

  a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (closed && !take) |=> closed);

  a_r6_result_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (closed && !take) |=> (q_row != $past(q_row) || q_col != $past(q_col) || q_hit == $past(q_hit)));

  a_r3_diag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (closed && refl_q && q_row == q_col) |-> q_hit);

  a_r8_row_matches_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (closed && q_src == q_row) |-> (reach_row[q_col] == q_hit));
endmodule

bind reach_closure reach_closure_chk #(.N(N), .IW(IW)) u_chk (.*);

// File: tb/tb_reach_closure.sv
`timescale 1ns/1ps
module tb_reach_closure;
  localparam int N     = 8;
  localparam int IW    = 3;
  localparam int STEPS = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           ld_valid = 1'b0;
  logic           ld_ready;
  logic [N*N-1:0] ld_rel = '0;
  logic           refl_mode = 1'b0;
  logic           step_en = 1'b0;
  logic           closed;
  logic [IW-1:0]  q_row = '0, q_col = '0, q_src = '0;
  logic           q_hit;
  logic [N-1:0]   reach_row;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  reach_closure #(.N(N), .IW(IW)) dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_rel(ld_rel), .refl_mode(refl_mode), .step_en(step_en), .closed(closed),
    .q_row(q_row), .q_col(q_col), .q_hit(q_hit), .q_src(q_src), .reach_row(reach_row)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N*N-1:0] ref_closure(input logic [N*N-1:0] rel, input bit refl);
    logic [N*N-1:0] e = rel;
    for (int k = 0; k < N; k++)
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (e[i*N+k] && e[k*N+j]) e[i*N+j] = 1'b1;
    if (refl) for (int i = 0; i < N; i++) e[i*N+i] = 1'b1;
    return e;
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  task automatic do_load(input logic [N*N-1:0] rel, input bit refl);
    @(negedge clk);
    ld_rel = rel; refl_mode = refl; ld_valid = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0;
    chk(ld_ready == 1'b0, "R2 ready low after load", ld_ready, 0);
  endtask

  task automatic verify(input logic [N*N-1:0] rel, input bit refl, input string tag);
    logic [N*N-1:0] exp = ref_closure(rel, refl);
    int bad = 0;
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) begin
        q_row = IW'(r); q_col = IW'(c); #0.1;
        if (q_hit !== exp[r*N+c]) begin
          bad++;
          $display("FAIL R7 %s pair %0d->%0d actual=%0b expected=%0b", tag, r, c, q_hit, exp[r*N+c]);
        end
      end
      q_src = IW'(r); #0.1;
      checks++;
      if (reach_row !== exp[r*N +: N]) begin
        errors++;
        $display("FAIL R8 %s row %0d actual=%0h expected=%0h", tag, r, reach_row, exp[r*N +: N]);
      end
    end
    checks++;
    if (bad != 0) errors++;
  endtask

  task automatic run_full(input logic [N*N-1:0] rel, input bit refl, input string tag);
    do_load(rel, refl);
    step_en = 1'b1;
    for (int s = 1; s <= STEPS; s++) begin
      @(negedge clk);
      if (s < STEPS) chk(closed == 1'b0, "R5 not done early", closed, 0);
      else           chk(closed == 1'b1, "R5 done after ceil(lg N) steps", closed, 1);
    end
    step_en = 1'b0;
    verify(rel, refl, tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N*N-1:0] chain, ring, g;
    chain = '0; ring = '0;
    for (int i = 0; i < N - 1; i++) chain[i*N + i + 1] = 1'b1;
    ring = chain; ring[(N-1)*N + 0] = 1'b1;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(closed == 1'b0, "R1 closed after reset", closed, 0);
    chk(ld_ready == 1'b1, "R1 ready after reset", ld_ready, 1);

    run_full(chain, 1'b0, "chain");   // R2 bit order, R7, R8
    run_full(ring, 1'b0, "ring");
    run_full('0, 1'b0, "empty");
    run_full('0, 1'b1, "empty-refl"); // R3
    run_full(chain, 1'b1, "chain-refl");
    for (int t = 0; t < 6; t++) begin
      logic [31:0] a, b, c;
      seed = nxt(seed); a = seed; seed = nxt(seed); b = seed; seed = nxt(seed); c = seed;
      g = {a, b} & {b ^ c, c} & {c, a ^ b};
      run_full(g, t[0], "random");
    end

    // R4: stalled steps do not count
    do_load(chain, 1'b0);
    begin
      bit pat [7] = '{1, 0, 0, 1, 0, 0, 1};
      int done_steps = 0;
      for (int i = 0; i < 7; i++) begin
        step_en = pat[i];
        @(negedge clk);
        if (pat[i]) done_steps++;
        chk(closed == (done_steps >= STEPS), "R4 step only when enabled", closed, done_steps >= STEPS);
      end
    end
    step_en = 1'b0;
    verify(chain, 1'b0, "stalled");

    // R6: done holds with step_en high
    step_en = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(closed == 1'b1, "R6 done holds", closed, 1);
    end
    step_en = 1'b0;
    verify(chain, 1'b0, "held");

    // R9: load offered while busy is refused
    do_load(chain, 1'b0);
    ld_rel = '1; refl_mode = 1'b1; ld_valid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(ld_ready == 1'b0, "R9 busy refuses load", ld_ready, 0);
    end
    ld_valid = 1'b0;
    step_en = 1'b1;
    repeat (STEPS) @(negedge clk);
    step_en = 1'b0;
    chk(closed == 1'b1, "R9 run finishes", closed, 1);
    chk(ld_ready == 1'b1, "R2 ready after done", ld_ready, 1);
    verify(chain, 1'b0, "refused");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule